// File: doc/BRIEF.md
# Read-Only Bus Responder with Strobe Handshake

This block is the peripheral end of a parallel, strobe-driven I/O bus. A bus master places an address and a direction level on the bus and then pulls an active-low request strobe. When the strobe falls while the direction line says "read" and the address lies inside the responder's aligned window, the responder pulls its active-low acknowledge line within a fixed number of clock cycles. It then turns on its data driver and presents one word from a small, constant read bank. It keeps acknowledge low for a set number of data cycles and raises it again to say that the word has been taken. The data driver is switched off as soon as the master lifts the strobe.

The shared data bus is three-state, but the buffer itself sits in the pad ring. This block produces the driver enable `rd_oe` and the value `rd_data`. Writes are a stub: they are never acknowledged.

The sequencer has five states. `ST_IDLE` waits for an accepted strobe edge. `ST_WAIT` is the reaction delay and is skipped when `REACT_CYC` is 1. `ST_ACK` lowers acknowledge with the driver still off. `ST_HOLD` keeps acknowledge low with data driven for `HOLD_CYC` cycles. `ST_RELEASE` raises acknowledge and keeps driving until the strobe rises. The transitions are:
- accept: `ST_IDLE` to `ST_WAIT` or `ST_ACK`.
- react-done: `ST_WAIT` to `ST_ACK`.
- drive: `ST_ACK` to `ST_HOLD`.
- consumed: `ST_HOLD` to `ST_RELEASE`.
- end: `ST_RELEASE` to `ST_IDLE`.
- abort: from any busy state to `ST_IDLE` when the strobe is seen high.

Top module: `bus_responder`

## Requirements
- R1: After reset, `rdy_n` is 1, `rd_oe` is 0 and `rd_data` is 0.
- R2: A read is accepted at the first clock edge that samples `req_n` low after it was sampled high, with `dir_rd`=1 and `addr` inside the window. Let that edge be the edge that accepts it. `rdy_n` goes low after edge `REACT_CYC`-1, counting from that edge as edge 0, and never later.
- R3: `rd_oe` rises exactly one cycle after `rdy_n` falls. While `rd_oe` is 1, `rd_data` equals bank word i, where i = addr - BASE_ADDR. Word i is (i*59 + 165) mod 2^DW, and it stays stable. While `rd_oe` is 0, `rd_data` is 0.
- R4: `rdy_n` stays low for `HOLD_CYC` cycles with data driven. It then returns to 1 while `rd_oe` is still 1.
- R5: After any edge that samples `req_n` high, `rdy_n` is 1 and `rd_oe` is 0 in the following cycle. This covers both a normal end and an abort at any point.
- R6: An address outside [BASE_ADDR, BASE_ADDR+WORDS) leaves `rdy_n` at 1 and `rd_oe` at 0.
- R7: A request with `dir_rd`=0 (write) is never acknowledged and never drives data.
- R8: A strobe held low after a transfer finishes causes no second response. A new response needs `req_n` sampled high and then low.
- R9: Changes on `addr` or `dir_rd` after acceptance do not alter the word delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 1 | Active-low request strobe from the master |
| dir_rd | input | 1 | Direction: 1 = read, 0 = write |
| addr | input | AW | Bus address |
| rdy_n | output | 1 | Active-low acknowledge / ready |
| rd_oe | output | 1 | Enable for the data-bus pad driver |
| rd_data | output | DW | Word presented to the data-bus driver |

## Verification
The in-RTL assertions watch the following on every cycle:
- The reaction-time bound, using a checker counter.
- The ordering of driver enable after acknowledge.
- That data stays stable while driven.
- That acknowledge rises only while data is still driven.
- That the bus is released after the strobe is seen high.

The word values, the rejection of out-of-range and write requests, the refusal to retrigger on a strobe held low, and the latching of the offset against later address changes are shown only by the bench's scenarios. In those scenarios the cycle-level reference model is compared against the ports on every clock.

// File: rtl/bus_resp_pkg.sv
package bus_resp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ACK,
        ST_HOLD,
        ST_RELEASE
    } resp_state_t;

    localparam int WORD_MUL = 59;
    localparam int WORD_ADD = 165;

    function automatic logic [31:0] bank_word(input int idx);
        return 32'(idx * WORD_MUL + WORD_ADD);
    endfunction

endpackage

// File: rtl/addr_window.sv
module addr_window #(
    parameter int          AW        = 16,
    parameter int          WORDS     = 8,
    parameter logic [31:0] BASE_ADDR = 32'h40
) (
    input  logic [AW-1:0]              addr,
    output logic                       hit,
    output logic [$clog2(WORDS)-1:0]   offset
);
    localparam int OW = $clog2(WORDS);
    localparam logic [AW-1:0] BASE_V = BASE_ADDR[AW-1:0];

    assign hit    = (addr[AW-1:OW] == BASE_V[AW-1:OW]);
    assign offset = addr[OW-1:0];

    initial begin
        assert (WORDS >= 2 && (1 << OW) == WORDS)
            else $error("WORDS must be a power of two >= 2");
    end
endmodule

// File: rtl/read_bank.sv
module read_bank #(
    parameter int DW    = 8,
    parameter int WORDS = 8
) (
    input  logic                     en,
    input  logic [$clog2(WORDS)-1:0] sel,
    output logic [DW-1:0]            word
);
    import bus_resp_pkg::*;

    logic [DW-1:0] words [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        localparam logic [31:0] VAL = bank_word(g);
        assign words[g] = VAL[DW-1:0];
    end

    assign word = en ? words[sel] : '0;
endmodule

// File: rtl/resp_fsm.sv
module resp_fsm #(
    parameter int OW        = 3,
    parameter int REACT_CYC = 1,
    parameter int HOLD_CYC  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_n,
    input  logic          dir_rd,
    input  logic          hit,
    input  logic [OW-1:0] offset,
    output logic          rdy_n,
    output logic          drive_en,
    output logic [OW-1:0] off_q
);
    import bus_resp_pkg::*;

    localparam int CNT_MAX = (REACT_CYC > HOLD_CYC) ? REACT_CYC : HOLD_CYC;
    localparam int CW      = $clog2(CNT_MAX + 1);

    resp_state_t state, nxt;
    logic          req_prev;
    logic [CW-1:0] wcnt, hcnt;
    logic          accept;

    assign accept = !req_n && req_prev && dir_rd && hit;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (accept) nxt = (REACT_CYC <= 1) ? ST_ACK : ST_WAIT;
            ST_WAIT:    if (req_n) nxt = ST_IDLE;
                        else if (int'(wcnt) == REACT_CYC - 2) nxt = ST_ACK;
            ST_ACK:     nxt = req_n ? ST_IDLE : ST_HOLD;
            ST_HOLD:    if (req_n) nxt = ST_IDLE;
                        else if (int'(hcnt) == HOLD_CYC - 1) nxt = ST_RELEASE;
            ST_RELEASE: if (req_n) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            req_prev <= 1'b1;
            wcnt     <= '0;
            hcnt     <= '0;
            off_q    <= '0;
        end else begin
            state    <= nxt;
            req_prev <= req_n;
            wcnt     <= (state == ST_WAIT) ? wcnt + 1'b1 : '0;
            hcnt     <= (state == ST_HOLD) ? hcnt + 1'b1 : '0;
            if (state == ST_IDLE && accept) off_q <= offset;
        end
    end

    always_comb begin
        rdy_n    = 1'b1;
        drive_en = 1'b0;
        unique case (state)
            ST_ACK:     rdy_n = 1'b0;
            ST_HOLD:    begin rdy_n = 1'b0; drive_en = 1'b1; end
            ST_RELEASE: drive_en = 1'b1;
            default:    ;
        endcase
    end

    // Checker: cycles from an accepted strobe edge to acknowledge
    logic        chk_prev;
    logic [31:0] pend;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_prev <= 1'b1;
            pend     <= '0;
        end else begin
            chk_prev <= req_n;
            if (pend == 0 && !req_n && chk_prev && dir_rd && hit && rdy_n)
                pend <= 32'd1;
            else if (pend != 0 && rdy_n && !req_n)
                pend <= pend + 32'd1;
            else
                pend <= '0;
        end
    end

    assert_react_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= 32'(REACT_CYC));

    assert_oe_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_en) |-> (!rdy_n && $past(!rdy_n)));

    assert_ack_release_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rdy_n) && !$past(req_n)) |-> drive_en);

    assert_bus_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_n) |-> (rdy_n && !drive_en));
endmodule

// File: rtl/bus_responder.sv
module bus_responder #(
    parameter int          AW        = 16,
    parameter int          DW        = 8,
    parameter int          WORDS     = 8,
    parameter logic [31:0] BASE_ADDR = 32'h40,
    parameter int          REACT_CYC = 1,
    parameter int          HOLD_CYC  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_n,
    input  logic          dir_rd,
    input  logic [AW-1:0] addr,
    output logic          rdy_n,
    output logic          rd_oe,
    output logic [DW-1:0] rd_data
);
    localparam int OW = $clog2(WORDS);

    logic          hit;
    logic [OW-1:0] offset, off_q;

    addr_window #(.AW(AW), .WORDS(WORDS), .BASE_ADDR(BASE_ADDR)) u_win (
        .addr(addr), .hit(hit), .offset(offset)
    );

    resp_fsm #(.OW(OW), .REACT_CYC(REACT_CYC), .HOLD_CYC(HOLD_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .dir_rd(dir_rd),
        .hit(hit), .offset(offset), .rdy_n(rdy_n), .drive_en(rd_oe), .off_q(off_q)
    );

    read_bank #(.DW(DW), .WORDS(WORDS)) u_bank (
        .en(rd_oe), .sel(off_q), .word(rd_data)
    );

    assert_data_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_oe && $past(rd_oe)) |-> $stable(rd_data));

    assert_idle_data_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_oe |-> (rd_data == '0));
endmodule

// File: tb/bus_responder_test.sv
module bus_responder_test;
    localparam int AW = 16, DW = 8, WORDS = 8;
    localparam int BASE = 'h40;
    localparam int REACT = 2, HOLD = 3;

    logic clk = 0, rst_n = 0, req_n = 1, dir_rd = 0;
    logic [AW-1:0] addr = '0;
    logic rdy_n, rd_oe;
    logic [DW-1:0] rd_data;

    int n_tests = 0, n_fail = 0;
    string cur_tag = "R1";

    always #4 clk = ~clk;

    bus_responder #(.AW(AW), .DW(DW), .WORDS(WORDS), .BASE_ADDR(32'(BASE)),
                    .REACT_CYC(REACT), .HOLD_CYC(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .dir_rd(dir_rd), .addr(addr),
        .rdy_n(rdy_n), .rd_oe(rd_oe), .rd_data(rd_data)
    );

    // Behavioural reference model
    bit m_act = 0, m_prev = 1;
    int m_t = 0, m_off = 0;
    bit e_rdy_n = 1, e_oe = 0;
    int e_data = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_prev = 1; m_t = 0;
        end else begin
            if (m_act) begin
                if (req_n) m_act = 0; else m_t++;
            end else if (!req_n && m_prev && dir_rd &&
                         int'(addr) >= BASE && int'(addr) < BASE + WORDS) begin
                m_act = 1; m_t = 0; m_off = int'(addr) - BASE;
            end
            m_prev = req_n;
        end
        e_rdy_n = !(m_act && m_t >= REACT - 1 && m_t <= REACT - 1 + HOLD);
        e_oe    = m_act && m_t >= REACT;
        e_data  = e_oe ? ((m_off * 59 + 165) % 256) : 0;
    end

    task automatic check(string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        check("R2 R4 rdy_n", int'(rdy_n), int'(e_rdy_n));
        check("R3 R5 rd_oe", int'(rd_oe), int'(e_oe));
        check("R3 rd_data", int'(rd_data), e_data);
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic txn(int a, bit rd, int low_cycles);
        addr = AW'(a); dir_rd = rd; req_n = 0;
        step(low_cycles);
        req_n = 1;
        step(3);
    endtask

    initial begin
        #(8 * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        step(3);
        cur_tag = "R1";
        check("R1 reset rdy_n", int'(rdy_n), 1);
        check("R1 reset rd_oe", int'(rd_oe), 0);
        rst_n = 1;
        step(2);

        cur_tag = "R2 R3 R4";
        for (int i = 0; i < WORDS; i++) txn(BASE + i, 1, REACT + HOLD + 2);

        cur_tag = "R6";
        txn(BASE - 1, 1, 8);
        txn(BASE + WORDS, 1, 8);
        txn(0, 1, 8);

        cur_tag = "R7";
        txn(BASE + 2, 0, 8);

        cur_tag = "R8";
        txn(BASE + 5, 1, 20);

        cur_tag = "R5";
        for (int k = 1; k <= REACT + HOLD + 1; k++) txn(BASE + 3, 1, k);

        cur_tag = "R9";
        addr = AW'(BASE + 6); dir_rd = 1; req_n = 0;
        step(1);
        addr = AW'(BASE + 1); dir_rd = 0;
        step(3);
        addr = AW'(BASE + WORDS + 4);
        step(4);
        req_n = 1;
        step(3);

        cur_tag = "R2 R5";
        txn(BASE + 7, 1, REACT + HOLD + 1);
        txn(BASE + 4, 1, REACT + HOLD + 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule